// File: doc/BRIEF.md
# SEU Memory Test Sequencer

This block drives a memory array through a simple synchronous command port to expose single-event upsets. The host picks one of several test modes and an 8-bit fill byte and pulses `start`. Depending on the mode, the sequencer first writes the byte, repeated across the word, into every location. It then sits in an open-ended hold phase while the part is irradiated, and leaves that phase only when the host pulses `proceed`. Finally it reads every location back and compares it with the expected word.

During the hold phase the mode decides what the array sees. It can see refresh commands only, or reads whose data is thrown away, or a continuous rewrite of the pattern. Other modes skip the fill. One of them first issues a precharge-all followed by a mode-register load. Another performs a single rewrite pass before the compare.

Every mismatching word is reported on a one-cycle error strobe. The report carries the word's address and the XOR of the read data against the expected data. A saturating counter accumulates the number of failing bits over the run. The memory is assumed to be a plain synchronous RAM that returns read data one cycle after the request.

Top module: `seuTestSeq`

## Requirements
- R1: In modes 0, 1 and 2 the sequencer first writes the pattern byte, replicated into every byte lane of the word, to each address from 0 up to DEPTH-1. Each write is one cycle with `memReq`=1, `memWe`=1 and `memCmd`=0.
- R2: After the fill, the hold phase lasts for any number of cycles until `proceed` is sampled high in it. A `proceed` outside the hold phase is ignored, and a `start` while `busy` is ignored.
- R3: In the mode-0 hold, every cycle is a refresh command (`memCmd`=1) and no read or write is issued.
- R4: In the mode-1 hold, every cycle is a read (`memCmd`=0, `memWe`=0) at an address that increments and wraps from DEPTH-1 to 0. No error is reported for these reads.
- R5: In the mode-2 hold, every cycle writes the pattern at an address that increments and wraps, so an upset cell is restored within DEPTH cycles.
- R6: The compare pass reads addresses 0 to DEPTH-1 in order. For each word whose data differs from the expected word, `errValid` pulses two cycles after the read request, with `errAddr` set to the address and `errBits` set to the read data XOR the expected word. Matching words produce no report.
- R7: `errTotal` is cleared on start and grows by the number of set bits in each mismatch. It saturates at all ones.
- R8: Mode 3, and the unused codes 6 and 7, perform only the compare pass, with no write.
- R9: Mode 4 issues exactly one precharge-all (`memCmd`=2) and, in the next cycle, one mode-register load (`memCmd`=3), then runs the compare pass with no write.
- R10: Mode 5 writes the pattern once to every address, then runs the compare pass.
- R11: `busy` is high from the cycle after an accepted start until `done`, which is a one-cycle pulse with `busy` already low. `done` falls in the same cycle as the report for the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (accepted only when idle) |
| mode | input | 3 | Test mode, sampled with start |
| pattern | input | 8 | Fill byte, sampled with start |
| proceed | input | 1 | Ends the hold phase |
| memReq | output | 1 | Memory command valid |
| memWe | output | 1 | Write enable for an access command |
| memCmd | output | 2 | 0 access, 1 refresh, 2 precharge-all, 3 mode-register load |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | DATA_W | Write data (replicated pattern) |
| memRdata | input | DATA_W | Read data, one cycle after the read request |
| errValid | output | 1 | Mismatch report strobe |
| errAddr | output | ADDR_W | Address of the mismatching word |
| errBits | output | DATA_W | Failing bit positions |
| errTotal | output | CNT_W | Saturating count of failing bits |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The error report for the final address and the end-of-run pulse share one cycle, and saturation of the bit counter may land on that same edge. The bench puts upsets in address DEPTH-1 so that `errValid` and `done` must rise together, and it judges the address, the bits and the total at that edge. A separate run flips every bit of every word so that the counter saturates in the middle of the pass and still holds its maximum when `done` fires. A scoreboard queue orders the expected reports by address, and the total is compared only on the `done` cycle.

// File: rtl/seuTestPkg.sv
package seuTestPkg;

  typedef enum logic [1:0] {
    CMD_ACCESS    = 2'd0,
    CMD_REFRESH   = 2'd1,
    CMD_PRECHARGE = 2'd2,
    CMD_MODELOAD  = 2'd3
  } memCmd_e;

  localparam logic [2:0] MODE_HOLD_REFRESH = 3'd0;
  localparam logic [2:0] MODE_HOLD_READ    = 3'd1;
  localparam logic [2:0] MODE_HOLD_WRITE   = 3'd2;
  localparam logic [2:0] MODE_CHECK_ONLY   = 3'd3;
  localparam logic [2:0] MODE_PRE_LOAD     = 3'd4;
  localparam logic [2:0] MODE_REWRITE      = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_HOLD,
    ST_PRECHG,
    ST_MODELD,
    ST_REWRITE,
    ST_READ,
    ST_DRAIN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic loadPat;
    logic cmpIssue;
    logic cmpLast;
  } seqStrobe_t;

endpackage

// File: rtl/seuBitCount.sv
module seuBitCount #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/seuTestCtrl.sv
module seuTestCtrl
  import seuTestPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic              proceed,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memCmd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output seqStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seqState_e         state, stateNext;
  logic [2:0]        modeReg;
  logic [ADDR_W-1:0] addrCnt, addrNext;
  logic              lastAddr;
  memCmd_e           cmdSel;

  assign lastAddr = (addrCnt == LAST_ADDR);

  always_comb begin
    stateNext = state;
    addrNext  = addrCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clearRun = 1'b1;
          strobe.loadPat  = 1'b1;
          addrNext        = '0;
          unique case (mode)
            MODE_HOLD_REFRESH,
            MODE_HOLD_READ,
            MODE_HOLD_WRITE:  stateNext = ST_FILL;
            MODE_PRE_LOAD:    stateNext = ST_PRECHG;
            MODE_REWRITE:     stateNext = ST_REWRITE;
            default:          stateNext = ST_READ;
          endcase
        end
      end
      ST_FILL: begin
        addrNext = addrCnt + 1'b1;
        if (lastAddr) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (modeReg != MODE_HOLD_REFRESH) addrNext = addrCnt + 1'b1;
        if (proceed) begin
          stateNext = ST_READ;
          addrNext  = '0;
        end
      end
      ST_PRECHG: stateNext = ST_MODELD;
      ST_MODELD: begin
        stateNext = ST_READ;
        addrNext  = '0;
      end
      ST_REWRITE: begin
        addrNext = addrCnt + 1'b1;
        if (lastAddr) stateNext = ST_READ;
      end
      ST_READ: begin
        strobe.cmpIssue = 1'b1;
        addrNext        = addrCnt + 1'b1;
        if (lastAddr) begin
          strobe.cmpLast = 1'b1;
          stateNext      = ST_DRAIN;
        end
      end
      ST_DRAIN: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrCnt <= '0;
      modeReg <= '0;
    end else begin
      state   <= stateNext;
      addrCnt <= addrNext;
      if (state == ST_IDLE && start) modeReg <= mode;
    end
  end

  always_comb begin
    cmdSel = CMD_ACCESS;
    if (state == ST_HOLD && modeReg == MODE_HOLD_REFRESH) cmdSel = CMD_REFRESH;
    else if (state == ST_PRECHG) cmdSel = CMD_PRECHARGE;
    else if (state == ST_MODELD) cmdSel = CMD_MODELOAD;
  end

  assign memReq  = (state inside {ST_FILL, ST_HOLD, ST_PRECHG, ST_MODELD,
                                  ST_REWRITE, ST_READ});
  assign memWe   = (state == ST_FILL) || (state == ST_REWRITE) ||
                   (state == ST_HOLD && modeReg == MODE_HOLD_WRITE);
  assign memCmd  = cmdSel;
  assign memAddr = addrCnt;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/seuTestDp.sv
module seuTestDp
  import seuTestPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [7:0]        pattern,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [DATA_W-1:0] errBits,
  output logic [CNT_W-1:0]  errTotal,
  output logic              done
);

  localparam int LANES = DATA_W / 8;
  localparam int PC_W  = $clog2(DATA_W + 1);

  logic [7:0]        patReg;
  logic [DATA_W-1:0] expWord;
  logic              pendValid, pendLast;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] diffWord;
  logic [PC_W-1:0]   diffCount;
  logic [CNT_W:0]    sumWide;
  logic [CNT_W-1:0]  sumSat;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign expWord[lane*8 +: 8] = patReg;
  end

  assign memWdata = expWord;
  assign diffWord = memRdata ^ expWord;

  seuBitCount #(.W(DATA_W)) bitCount_i (
    .vec   (diffWord),
    .count (diffCount)
  );

  assign sumWide = {1'b0, errTotal} + (CNT_W + 1)'(diffCount);
  assign sumSat  = sumWide[CNT_W] ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patReg    <= '0;
      pendValid <= 1'b0;
      pendLast  <= 1'b0;
      pendAddr  <= '0;
      errValid  <= 1'b0;
      errAddr   <= '0;
      errBits   <= '0;
      errTotal  <= '0;
      done      <= 1'b0;
    end else begin
      if (strobe.loadPat) patReg <= pattern;
      pendValid <= strobe.cmpIssue;
      pendLast  <= strobe.cmpLast;
      pendAddr  <= issueAddr;
      errValid  <= pendValid && (diffWord != '0);
      done      <= pendValid && pendLast;
      if (pendValid && diffWord != '0) begin
        errAddr <= pendAddr;
        errBits <= diffWord;
      end
      if (strobe.clearRun) errTotal <= '0;
      else if (pendValid)  errTotal <= sumSat;
    end
  end

endmodule

// File: rtl/seuTestSeq.sv
module seuTestSeq
  import seuTestPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [7:0]        pattern,
  input  logic              proceed,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memCmd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [DATA_W-1:0] errBits,
  output logic [CNT_W-1:0]  errTotal,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strobe;

  seuTestCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (mode),
    .proceed (proceed),
    .memReq  (memReq),
    .memWe   (memWe),
    .memCmd  (memCmd),
    .memAddr (memAddr),
    .busy    (busy),
    .strobe  (strobe)
  );

  seuTestDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pattern   (pattern),
    .issueAddr (memAddr),
    .memRdata  (memRdata),
    .memWdata  (memWdata),
    .errValid  (errValid),
    .errAddr   (errAddr),
    .errBits   (errBits),
    .errTotal  (errTotal),
    .done      (done)
  );

endmodule

// File: rtl/seuTestChk.sv
module seuTestChk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              errValid,
  input logic [DATA_W-1:0] errBits,
  input logic [CNT_W-1:0]  errTotal,
  input logic              memReq,
  input logic              memWe,
  input logic [1:0]        memCmd,
  input logic [ADDR_W-1:0] memAddr
);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_in_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> $past(busy));

  p_err_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errBits != '0));

  p_total_grows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (errTotal >= $past(errTotal)));

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  p_write_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memCmd == 2'd0));

endmodule

bind seuTestSeq seuTestChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .errValid (errValid),
  .errBits  (errBits),
  .errTotal (errTotal),
  .memReq   (memReq),
  .memWe    (memWe),
  .memCmd   (memCmd),
  .memAddr  (memAddr)
);

// File: tb/seuTestSeq_tb_top.sv
module seuTestSeq_tb_top;

  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int CW    = 7;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [7:0]    pattern = '0;
  logic          proceed = 1'b0;
  logic          memReq, memWe;
  logic [1:0]    memCmd;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;
  logic          errValid;
  logic [AW-1:0] errAddr;
  logic [DW-1:0] errBits;
  logic [CW-1:0] errTotal;
  logic          busy, done;

  always #10 clk = ~clk;

  seuTestSeq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pattern(pattern),
    .proceed(proceed), .memReq(memReq), .memWe(memWe), .memCmd(memCmd),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .errValid(errValid), .errAddr(errAddr), .errBits(errBits),
    .errTotal(errTotal), .busy(busy), .done(done)
  );

  // memory model with a side port for upset injection
  logic [DW-1:0] ram [DEPTH];
  logic          injReq = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [DW-1:0] injVal = '0;
  int nWr = 0, nRd = 0, nRef = 0, nPre = 0, nMrs = 0, cyc = 0;
  int preCyc = 0, mrsCyc = 0;

  initial memRdata = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && memReq) begin
      case (memCmd)
        2'd0: begin
          if (memWe) begin
            ram[memAddr] <= memWdata;
            nWr <= nWr + 1;
          end else begin
            memRdata <= ram[memAddr];
            nRd <= nRd + 1;
          end
        end
        2'd1: nRef <= nRef + 1;
        2'd2: begin nPre <= nPre + 1; preCyc <= cyc; end
        default: begin nMrs <= nMrs + 1; mrsCyc <= cyc; end
      endcase
    end
    if (injReq) ram[injAddr] <= injVal;
  end

  // scoreboard
  int expAddrQ[$];
  int expBitsQ[$];
  int rdIdx = 0;
  int monChecks = 0, monFails = 0;

  always @(negedge clk) begin
    if (rstN && errValid) begin
      monChecks = monChecks + 1;
      if (rdIdx >= expAddrQ.size()) begin
        monFails = monFails + 1;
        $display("FAIL R6: unexpected report addr=%0d bits=%h, expected none", errAddr, errBits);
      end else begin
        if (int'(errAddr) != expAddrQ[rdIdx] || int'(errBits) != expBitsQ[rdIdx]) begin
          monFails = monFails + 1;
          $display("FAIL R6: report addr=%0d bits=%h, expected addr=%0d bits=%h",
                   errAddr, errBits, expAddrQ[rdIdx], expBitsQ[rdIdx]);
        end
        rdIdx = rdIdx + 1;
      end
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectErr(input int a, input int bits);
    expAddrQ.push_back(a);
    expBitsQ.push_back(bits);
  endtask

  task automatic runStart(input logic [2:0] m, input logic [7:0] p);
    @(negedge clk); start = 1'b1; mode = m; pattern = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseProceed();
    @(negedge clk); proceed = 1'b1;
    @(negedge clk); proceed = 1'b0;
  endtask

  task automatic setWord(input int a, input logic [DW-1:0] v);
    @(negedge clk); injReq = 1'b1; injAddr = AW'(a); injVal = v;
    @(negedge clk); injReq = 1'b0;
  endtask

  task automatic flip(input int a, input logic [DW-1:0] mask);
    setWord(a, ram[a] ^ mask);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for done, then judges total, coincident report and pulse width
  task automatic finishRun(input int expTotal, input bit lastErr, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(seen, "R11", seen, 1);
    chk(!busy, "R11", busy, 0);
    chk(errValid == lastErr, "R11", errValid, lastErr);
    chk(int'(errTotal) == expTotal, req, errTotal, expTotal);
    @(negedge clk);
    chk(!done, "R11", done, 0);
    chk(rdIdx == expAddrQ.size(), "R6", rdIdx, expAddrQ.size());
  endtask

  initial begin
    int w0, r0, ref0, pre0, mrs0;
    bit ok, wrapped;
    logic [AW-1:0] prevA;

    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !done && !errValid && !memReq, "R11", {busy, done, errValid, memReq}, 0);
    chk(errTotal == 0, "R7", errTotal, 0);
    rstN = 1'b1;
    idle(2);

    // mode 0: fill, refresh hold, compare
    w0 = nWr;
    runStart(3'd0, 8'hA5);
    chk(busy, "R11", busy, 1);
    idle(30);
    ok = 1'b1;
    for (int a = 0; a < DEPTH; a++) if (ram[a] != 16'hA5A5) ok = 1'b0;
    chk(ok, "R1", ok, 1);
    chk(nWr - w0 == DEPTH, "R1", nWr - w0, DEPTH);
    w0 = nWr; r0 = nRd; ref0 = nRef;
    idle(10);
    chk(nRef - ref0 == 10, "R3", nRef - ref0, 10);
    chk(nWr == w0 && nRd == r0, "R3", (nWr - w0) + (nRd - r0), 0);
    runStart(3'd3, 8'h00);   // ignored while busy
    idle(100);
    chk(busy && memCmd == 2'd1, "R2", {busy, memCmd}, 3'b101);
    flip(3, 16'h0001);
    flip(15, 16'h8000);
    expectErr(3, 16'h0001);
    expectErr(15, 16'h8000);
    pulseProceed();
    finishRun(2, 1'b1, "R7");

    // mode 1: blank-read hold with early proceed ignored
    runStart(3'd1, 8'h00);
    idle(4);
    pulseProceed();
    idle(30);
    chk(busy && memReq && !memWe && memCmd == 2'd0, "R2", {busy, memReq, memWe, memCmd}, 5'b11000);
    ok = 1'b1; wrapped = 1'b0;
    prevA = memAddr;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memAddr != prevA + 1'b1 || memWe || memCmd != 2'd0) ok = 1'b0;
      if (memAddr == '0) wrapped = 1'b1;
      prevA = memAddr;
    end
    chk(ok && wrapped, "R4", {ok, wrapped}, 2'b11);
    flip(7, 16'h0300);
    expectErr(7, 16'h0300);
    pulseProceed();
    finishRun(2, 1'b0, "R7");

    // mode 2: rewrite hold restores an upset
    runStart(3'd2, 8'hFF);
    idle(30);
    w0 = nWr;
    idle(20);
    chk(nWr - w0 == 20, "R5", nWr - w0, 20);
    flip(5, 16'h00F0);
    idle(20);
    chk(ram[5] == 16'hFFFF, "R5", ram[5], 16'hFFFF);
    pulseProceed();
    finishRun(0, 1'b0, "R5");

    // mode 3: compare only, last address upset
    flip(0, 16'hFFFF);
    flip(15, 16'h0001);
    expectErr(0, 16'hFFFF);
    expectErr(15, 16'h0001);
    w0 = nWr;
    runStart(3'd3, 8'hFF);
    finishRun(17, 1'b1, "R8");
    chk(nWr == w0, "R8", nWr - w0, 0);

    // mode 4: precharge-all then mode-register load, then compare
    flip(9, 16'h1000);
    expectErr(0, 16'hFFFF);
    expectErr(9, 16'h1000);
    expectErr(15, 16'h0001);
    w0 = nWr; pre0 = nPre; mrs0 = nMrs;
    runStart(3'd4, 8'hFF);
    finishRun(18, 1'b1, "R9");
    chk(nPre - pre0 == 1 && nMrs - mrs0 == 1, "R9", {nPre - pre0, nMrs - mrs0}, 2);
    chk(mrsCyc == preCyc + 1, "R9", mrsCyc - preCyc, 1);
    chk(nWr == w0, "R9", nWr - w0, 0);

    // mode 5: one rewrite pass then compare
    w0 = nWr;
    runStart(3'd5, 8'h3C);
    finishRun(0, 1'b0, "R10");
    chk(nWr - w0 == DEPTH, "R10", nWr - w0, DEPTH);
    ok = 1'b1;
    for (int a = 0; a < DEPTH; a++) if (ram[a] != 16'h3C3C) ok = 1'b0;
    chk(ok, "R10", ok, 1);

    // unused code 7 behaves as compare only
    flip(2, 16'h0004);
    expectErr(2, 16'h0004);
    w0 = nWr;
    runStart(3'd7, 8'h3C);
    finishRun(1, 1'b0, "R8");
    chk(nWr == w0, "R8", nWr - w0, 0);

    // saturation of the failing-bit total
    for (int a = 0; a < DEPTH; a++) setWord(a, 16'hFFFF);
    for (int a = 0; a < DEPTH; a++) expectErr(a, 16'hFFFF);
    runStart(3'd3, 8'h00);
    finishRun(127, 1'b1, "R7");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks + monChecks, nFails + monFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks + monChecks + 1, nFails + monFails + 1);
      $finish;
    end
  end

endmodule